// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Datapath

This block is the datapath of a 32-bit load/store processor that runs each instruction as a series of clock steps. One memory port serves both instruction fetch and data access. One ALU does the program-counter increment, the branch-target sum, the effective-address sum and the register-to-register arithmetic. Each of these jobs falls in a different cycle. Values that one step hands to a later step are held in internal registers that software never sees: an instruction word register, a memory data register, two operand registers and an ALU result register.

Everything that decides what happens in a given cycle comes in on input pins: write strobes, operand selects, the ALU mode, the next-PC choice and the memory address choice. A separate sequencer drives these pins. The datapath returns the opcode field of the held instruction and the ALU zero flag to that sequencer. The instruction set covered is word load, word store, register add, subtract, and, or and set-less-than, branch-if-equal and absolute jump.

Top module: `mc_datapath`

## Requirements
- R1: When reset is sampled high, the PC takes `RESET_PC`, and the instruction register, every register-file entry and the other holding registers clear to zero. Right after reset, `mem_addr` with `addr_sel`=0 shows `RESET_PC`, `opcode` is 0 and `mem_wdata` is 0.
- R2: The instruction register captures `mem_rdata` on an edge only when `ir_we` is 1; otherwise it keeps its value. `opcode` shows bits 31:26 of the held word.
- R3: `src_b_sel` picks the second ALU operand. 00 gives the B register, 01 gives the constant 4, 10 gives bits 15:0 of the instruction sign-extended, and 11 gives that sign-extended value shifted left by two. `src_a_sel` picks the PC when 0 and the A register when 1.
- R4: `alu_mode` 00 adds and 01 subtracts. 10 decodes instruction bits 5:0: 0x20 adds, 0x22 subtracts, 0x24 is bitwise and, 0x25 is bitwise or, and 0x2A gives 1 when A is less than B as signed numbers and 0 otherwise.
- R5: The PC loads on an edge when `pc_we` is 1, or when `pc_we_cond` is 1 and `zero` is 1. Otherwise it holds.
- R6: `pc_src` picks the new PC. 00 takes the live ALU result, 01 takes the ALU result register, and 10 takes the upper four PC bits joined with instruction bits 25:0 and two zero bits.
- R7: `mem_addr` is the PC when `addr_sel` is 0 and the ALU result register when it is 1. `mem_wdata` is always the B register.
- R8: The A register loads the entry named by instruction bits 25:21, and B loads the entry named by bits 20:16. A register-file write goes to bits 20:16 when `dst_sel` is 0 and to bits 15:11 when it is 1.
- R9: Register-file write data is the ALU result register when `wd_sel` is 0 and the memory data register when it is 1. The memory data register, A, B and the ALU result register load on every edge.
- R10: Entry 0 of the register file always reads zero, and writes to it have no effect.
- R11: `zero` is 1 exactly when the current ALU result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write gated by the zero flag |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_we | input | 1 | Instruction register capture |
| rf_we | input | 1 | Register-file write |
| dst_sel | input | 1 | Write address: 0 bits 20:16, 1 bits 15:11 |
| wd_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| src_a_sel | input | 1 | ALU operand A: 0 PC, 1 A register |
| src_b_sel | input | 2 | ALU operand B code |
| alu_mode | input | 2 | ALU mode code |
| pc_src | input | 2 | Next-PC source code |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Address to the shared memory |
| mem_wdata | output | 32 | Write data to the shared memory |
| opcode | output | 6 | Opcode field of the held instruction |
| zero | output | 1 | ALU result is zero |

## Verification
The bench acts as the sequencer and runs whole instructions through the datapath. It goes after the corner cases where the shared units are easy to get wrong. A datapath that picked the wrong immediate form would send a load with a negative offset, or a branch target, to the wrong address. One that wrote the wrong destination field would corrupt a register whose number only appears in bits 15:11 of a load. One that let register 0 keep a loaded value would make a later store emit nonzero data. Signed set-less-than is tested with a mix of signs: an unsigned compare gives the opposite answer. A not-taken branch checks that the conditional strobe alone does not move the PC. With the capture strobe low and a different word on the bus, a holding failure in the instruction register would show up as a changed opcode.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;

    typedef enum logic {
        ASRC_PC  = 1'b0,
        ASRC_REG = 1'b1
    } asrc_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'b00,
        BSRC_FOUR = 2'b01,
        BSRC_IMM  = 2'b10,
        BSRC_IMM4 = 2'b11
    } bsrc_e;

    typedef enum logic [1:0] {
        NPC_ALU  = 2'b00,
        NPC_HOLD = 2'b01,
        NPC_JUMP = 2'b10
    } npc_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_SLT
    } alu_fn_e;

    localparam logic [5:0] FUNCT_ADD = 6'h20;
    localparam logic [5:0] FUNCT_SUB = 6'h22;
    localparam logic [5:0] FUNCT_AND = 6'h24;
    localparam logic [5:0] FUNCT_OR  = 6'h25;
    localparam logic [5:0] FUNCT_SLT = 6'h2A;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alu_fn_e pick_fn(input logic [1:0] mode, input logic [5:0] funct);
        alu_fn_e f;
        case (mode)
            2'b01:   f = FN_SUB;
            2'b10: begin
                case (funct)
                    FUNCT_SUB: f = FN_SUB;
                    FUNCT_AND: f = FN_AND;
                    FUNCT_OR:  f = FN_OR;
                    FUNCT_SLT: f = FN_SLT;
                    default:   f = FN_ADD;
                endcase
            end
            default: f = FN_ADD;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int DW   = XLEN,
    parameter int NR   = NREG
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [$clog2(NR)-1:0] wa,
    input  logic [DW-1:0]         wd,
    input  logic [$clog2(NR)-1:0] ra1,
    input  logic [$clog2(NR)-1:0] ra2,
    output logic [DW-1:0]         rd1,
    output logic [DW-1:0]         rd2
);
    localparam int AW = $clog2(NR);

    logic [DW-1:0] row [NR];

    for (genvar g = 0; g < NR; g++) begin : g_row
        if (g == 0) begin : g_hard_zero
            always_ff @(posedge clk) row[g] <= '0;
        end else begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    row[g] <= '0;
                else if (we && wa == AW'(g))
                    row[g] <= wd;
            end
        end
    end

    assign rd1 = row[ra1];
    assign rd2 = row[ra2];

    // R10
    zero_row_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> (row[0] == '0));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [1:0]    mode,
    input  logic [5:0]    funct,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);
    alu_fn_e fn;

    assign fn = pick_fn(mode, funct);

    always_comb begin
        case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_we,
    input  logic        pc_we_cond,
    input  logic        addr_sel,
    input  logic        ir_we,
    input  logic        rf_we,
    input  logic        dst_sel,
    input  logic        wd_sel,
    input  logic        src_a_sel,
    input  logic [1:0]  src_b_sel,
    input  logic [1:0]  alu_mode,
    input  logic [1:0]  pc_src,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [5:0]  opcode,
    output logic        zero
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] pc, mdr_q, a_q, b_q, alu_q;
    instr_t          ir;
    logic [XLEN-1:0] ir_w, imm_x;
    logic [XLEN-1:0] rd1, rd2, rf_wd, op_a, op_b, alu_y, pc_next;
    logic [AW-1:0]   rf_wa;
    logic            pc_load;

    assign ir_w  = ir;
    assign imm_x = sext16(ir_w[15:0]);

    // operand steering
    always_comb begin
        op_a = (asrc_e'(src_a_sel) == ASRC_REG) ? a_q : pc;
        case (bsrc_e'(src_b_sel))
            BSRC_FOUR: op_b = XLEN'(4);
            BSRC_IMM:  op_b = imm_x;
            BSRC_IMM4: op_b = {imm_x[XLEN-3:0], 2'b00};
            default:   op_b = b_q;
        endcase
    end

    // next-PC steering
    always_comb begin
        case (npc_e'(pc_src))
            NPC_HOLD: pc_next = alu_q;
            NPC_JUMP: pc_next = {pc[XLEN-1:XLEN-4], ir_w[25:0], 2'b00};
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_we || (pc_we_cond && zero);
    assign rf_wa   = dst_sel ? ir.rd : ir.rt;
    assign rf_wd   = wd_sel ? mdr_q : alu_q;

    mc_regfile #(.DW(XLEN), .NR(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd),
        .ra1 (ir.rs),
        .ra2 (ir.rt),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    mc_alu #(.DW(XLEN)) u_alu (
        .mode  (alu_mode),
        .funct (ir.funct),
        .a     (op_a),
        .b     (op_b),
        .y     (alu_y),
        .zero  (zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= RESET_PC;
            ir    <= '0;
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
        end else begin
            if (pc_load) pc <= pc_next;
            if (ir_we)   ir <= instr_t'(mem_rdata);
            mdr_q <= mem_rdata;
            a_q   <= rd1;
            b_q   <= rd2;
            alu_q <= alu_y;
        end
    end

    assign mem_addr  = addr_sel ? alu_q : pc;
    assign mem_wdata = b_q;
    assign opcode    = ir.op;

    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !(pc_we_cond && zero)) |=> $stable(pc));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == 2'b00 && !src_a_sel && src_b_sel == 2'b01 && alu_mode == 2'b00)
        |=> (pc == $past(pc) + 32'd4));

    // R5
    pc_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we_cond && zero && pc_src == 2'b01) |=> (pc == $past(alu_q)));

    // R6
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == 2'b10)
        |=> (pc == {$past(pc[31:28]), $past(ir_w[25:0]), 2'b00}));

    // R10
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ir.rs == '0) |=> (a_q == '0));

endmodule

// File: tb/test_mc_datapath.sv
module test_mc_datapath;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BOOT = 32'h0000_0100;
    localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B,
                           OP_BEQ = 6'h04, OP_J = 6'h02;

    typedef struct packed {
        logic [5:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'h20, 32'd5,          32'd7,          32'd12},
        '{6'h20, 32'hFFFF_FFFF,  32'd1,          32'd0},
        '{6'h22, 32'd3,          32'd5,          32'hFFFF_FFFE},
        '{6'h24, 32'hF0F0_1234,  32'h0FF0_FF00,  32'h00F0_1200},
        '{6'h25, 32'h0F00_0000,  32'h0000_00F0,  32'h0F00_00F0},
        '{6'h2A, 32'hFFFF_FFFF,  32'd1,          32'd1},
        '{6'h2A, 32'd5,          32'hFFFF_FFFD,  32'd0},
        '{6'h2A, 32'd7,          32'd7,          32'd0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic pc_we, pc_we_cond, addr_sel, ir_we, rf_we, dst_sel, wd_sel, src_a_sel;
    logic [1:0] src_b_sel, alu_mode, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode;
    logic        zero;

    logic [31:0] mem [256];
    logic [31:0] rm  [32];
    logic [31:0] pc_m;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mc_datapath #(.RESET_PC(BOOT)) i_mc_datapath (
        .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .addr_sel(addr_sel), .ir_we(ir_we), .rf_we(rf_we), .dst_sel(dst_sel),
        .wd_sel(wd_sel), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
        .alu_mode(alu_mode), .pc_src(pc_src), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .zero(zero)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; pc_we_cond = 0; addr_sel = 0; ir_we = 0; rf_we = 0;
        dst_sel = 0; wd_sel = 0; src_a_sel = 0; src_b_sel = 2'b00;
        alu_mode = 2'b00; pc_src = 2'b00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    task automatic chk_pc(input string tag);
        idle();
        #1 chk(tag, mem_addr, pc_m);
    endtask

    // runs one instruction through the step sequence a sequencer would issue
    task automatic run(input logic [31:0] w, input logic [31:0] rexp);
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd;
        logic [31:0] ea;
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
        ea = rm[rs] + sx(w[15:0]);
        mem[pc_m[9:2]] = w;
        // fetch
        idle(); ir_we = 1; src_b_sel = 2'b01; pc_we = 1;
        #1 chk("R2 fetch address", mem_addr, pc_m);
        tick();
        pc_m = pc_m + 4;
        // decode and branch-target sum
        idle(); src_b_sel = 2'b11;
        #1 chk("R2 opcode", {26'd0, opcode}, {26'd0, op});
        tick();
        case (op)
            OP_LW, OP_SW: begin
                idle(); src_a_sel = 1; src_b_sel = 2'b10;
                tick();
                idle(); addr_sel = 1;
                #1 chk("R3 data address", mem_addr, ea);
                if (op == OP_SW) begin
                    chk("R7 store data", mem_wdata, rm[rt]);
                    mem[mem_addr[9:2]] = mem_wdata;
                end
                tick();
                if (op == OP_LW) begin
                    idle(); wd_sel = 1; rf_we = 1;
                    tick();
                    if (rt != 0) rm[rt] = mem[ea[9:2]];
                end
            end
            OP_R: begin
                idle(); src_a_sel = 1; alu_mode = 2'b10;
                tick();
                idle(); dst_sel = 1; rf_we = 1;
                tick();
                if (rd != 0) rm[rd] = rexp;
            end
            OP_BEQ: begin
                idle(); src_a_sel = 1; alu_mode = 2'b01; pc_src = 2'b01; pc_we_cond = 1;
                #1 chk("R11 zero flag", {31'd0, zero}, {31'd0, rm[rs] == rm[rt]});
                tick();
                if (rm[rs] == rm[rt]) pc_m = pc_m + {sx(w[15:0]), 2'b00};
            end
            OP_J: begin
                idle(); pc_src = 2'b10; pc_we = 1;
                tick();
                pc_m = {pc_m[31:28], w[25:0], 2'b00};
            end
            default: ;
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) rm[i] = '0;
        pc_m = BOOT;
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: state just after reset
        #1;
        chk("R1 reset PC", mem_addr, BOOT);
        chk("R1 reset opcode", {26'd0, opcode}, 32'd0);
        chk("R1 reset B", mem_wdata, 32'd0);

        // R4 / R9: ALU vector table, each pushed through load, op, store
        for (int i = 0; i < 8; i++) begin
            mem[0] = VECS[i].a;
            mem[1] = VECS[i].b;
            run(enc_i(OP_LW, 0, 1, 16'd0), '0);
            run(enc_i(OP_LW, 0, 2, 16'd4), '0);
            run(enc_r(1, 2, 3, VECS[i].fn), VECS[i].y);
            run(enc_i(OP_SW, 0, 3, 16'd8), '0);
            chk("R4 alu result stored", mem[2], VECS[i].y);
        end

        // R10: load into entry 0, then store it
        mem[0] = 32'hDEAD_BEEF;
        run(enc_i(OP_LW, 0, 0, 16'd0), '0);
        run(enc_i(OP_SW, 0, 0, 16'd12), '0);
        chk("R10 r0 after load", mem[3], 32'd0);
        run(enc_r(1, 2, 0, 6'h25), 32'hFFFF_FFFF);
        run(enc_i(OP_SW, 0, 0, 16'd12), '0);
        chk("R10 r0 after op", mem[3], 32'd0);

        // R8: load whose bits 15:11 name entry 1 must write only entry 6
        mem[2] = 32'h1234_5678;
        keep = rm[1];
        run(enc_i(OP_LW, 0, 6, 16'h0808), '0);
        run(enc_i(OP_SW, 0, 6, 16'd12), '0);
        chk("R8 rt written", mem[3], 32'h1234_5678);
        run(enc_i(OP_SW, 0, 1, 16'd12), '0);
        chk("R8 rd field untouched", mem[3], keep);

        // R3: negative displacement
        mem[1] = 32'd8;
        run(enc_i(OP_LW, 0, 5, 16'd4), '0);
        run(enc_i(OP_LW, 5, 4, 16'hFFFC), '0);
        run(enc_i(OP_SW, 0, 4, 16'd12), '0);
        chk("R3 negative offset load", mem[3], 32'd8);

        // R5: branch taken and not taken
        run(enc_i(OP_BEQ, 4, 5, 16'd1), '0);
        chk_pc("R5 branch taken");
        run(enc_i(OP_BEQ, 0, 5, 16'd3), '0);
        chk_pc("R5 branch not taken");

        // R6: absolute jump
        run({OP_J, 26'h00000C0}, '0);
        chk_pc("R6 jump target");
        run(enc_r(4, 5, 7, 6'h20), 32'd16);
        run(enc_i(OP_SW, 0, 7, 16'd12), '0);
        chk("R9 result after jump", mem[3], 32'd16);

        // R2 / R5: capture and PC strobes low with a new word on the bus
        mem[pc_m[9:2]] = enc_i(OP_LW, 0, 9, 16'd0);
        idle(); src_b_sel = 2'b01;
        tick();
        #1;
        chk("R2 ir held", {26'd0, opcode}, {26'd0, OP_SW});
        chk("R5 pc held", mem_addr, pc_m);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule